// File: doc/BRIEF.md
# Priority Vectored Interrupt Controller

This block gathers eight active-high, level-sensitive interrupt request lines and arbitrates between them by fixed priority. Line 0 ranks highest and line 7 lowest. When a request wins, the block raises a single interrupt output towards the processor. The processor answers with a one-cycle acknowledge pulse. The block then presents an 8-bit vector for the winning line, built from a 5-bit base followed by the 3-bit line number.

Each acknowledged line is recorded as in service. While a handler runs, only a request of strictly higher priority can raise the interrupt output again, so handlers nest by priority. An end-of-interrupt pulse retires the highest-priority in-service line. A mask register holds requests out of arbitration without losing them.

For systems with more than eight sources, line 2 can be declared a cascade input. A second, identical controller then drives that line with its own interrupt output. When the cascade line wins, this block does not present a vector. Instead it emits a cascade acknowledge pulse, which feeds the second controller's acknowledge input, and that controller supplies the vector. Fifteen sources are usable this way.

Top module: `irq_vec_ctrl`

## Requirements
- R1: While reset is asserted and on its release, `intr`, `vec_valid` and `cas_ack` are 0 and the mask register is 0x00 (all lines enabled).
- R2: Among requests that are pending and unmasked, the lowest line index wins arbitration. Line 0 has the highest priority.
- R3: When `inta` is sampled high while `intr` is high, `vec_valid` is high in the next cycle for exactly one cycle. In that cycle `vec_data` = {`vec_base`, 3-bit winning line index}.
- R4: Once a request has been sampled, `intr` is high if that request is pending and unmasked and no line of equal or higher priority is in service.
- R5: A request that outranks the highest-priority in-service line raises `intr` (pre-emption). A request of equal or lower priority leaves `intr` low.
- R6: A line whose bit is set in the mask register (bit i masks line i, written through `mask_we`/`mask_wdata`) cannot raise `intr`. Its request stays pending and is served once the bit is cleared.
- R7: A request that is high for a single cycle stays pending until it is acknowledged. On acknowledge, the winning line's in-service bit is set and its pending bit is cleared.
- R8: An `eoi` pulse clears only the highest-priority set in-service bit.
- R9: With `cascade_en` high, if line 2 wins an acknowledge, then in the next cycle `cas_ack` pulses for one cycle instead of `vec_valid`.
- R10: An `inta` pulse while `intr` is low produces neither `vec_valid` nor `cas_ack` and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 8 | Level interrupt requests, bit i is line i |
| mask_we | input | 1 | Write strobe for the mask register |
| mask_wdata | input | 8 | New mask value, bit i masks line i |
| vec_base | input | 5 | Upper five bits of every vector |
| cascade_en | input | 1 | Treat line 2 as the link to a second controller |
| inta | input | 1 | Processor acknowledge pulse |
| eoi | input | 1 | End-of-interrupt pulse |
| intr | output | 1 | Interrupt request to the processor |
| vec_valid | output | 1 | Vector on vec_data is valid this cycle |
| vec_data | output | 8 | Vector of the acknowledged line |
| cas_ack | output | 1 | Acknowledge passed to the second controller |

## Verification
The bench targets the following corner cases:
- A higher request arriving while a lower handler is in service. A design that ignored in-service state would fail to pre-empt, or would let an equal or lower request interrupt a running handler.
- Several simultaneous requests. A design with reversed priority would hand out the vector of line 7 first.
- A request masked and later unmasked. A design that dropped masked requests would never serve it.
- Back-to-back end-of-interrupt pulses. A design that cleared the wrong in-service bit would raise the interrupt output too early.
- The cascade line, and an acknowledge with no interrupt pending. A broken design would emit its own vector for the cascade line, or a stray vector for the spurious acknowledge.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

  // Kind of response launched by an acknowledge, registered for one cycle.
  typedef enum logic [1:0] {
    ACK_IDLE    = 2'd0,
    ACK_LOCAL   = 2'd1,
    ACK_CASCADE = 2'd2
  } ack_kind_e;

endpackage

// File: rtl/irq_prio_enc.sv
// Finds the lowest set index of a vector (lowest index = highest priority).
module irq_prio_enc #(
  parameter int N_LINES = 8,
  localparam int IDX_W  = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input  logic [N_LINES-1:0] bits_i,
  output logic               found_o,
  output logic [IDX_W-1:0]   idx_o
);

  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N_LINES - 1; i >= 0; i--) begin
      if (bits_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/irq_pend_bank.sv
// Pending latches and mask register.
module irq_pend_bank #(
  parameter int N_LINES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] req_i,
  input  logic [N_LINES-1:0] clr_oh_i,
  input  logic               mask_we_i,
  input  logic [N_LINES-1:0] mask_wdata_i,
  output logic [N_LINES-1:0] pend_o,
  output logic [N_LINES-1:0] mask_o
);

  logic [N_LINES-1:0] pend_q, pend_d;
  logic [N_LINES-1:0] mask_q, mask_d;
  logic               pend_en;

  // Next state: a clear from acknowledge wins over a request in the same cycle.
  always_comb begin
    pend_d  = (pend_q | req_i) & ~clr_oh_i;
    pend_en = (|req_i) | (|clr_oh_i);
    mask_d  = mask_wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else if (pend_en) begin
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_we_i) begin
      mask_q <= mask_d;
    end
  end

  assign pend_o = pend_q;
  assign mask_o = mask_q;

endmodule

// File: rtl/irq_isr_track.sv
// In-service register: set by acknowledge, highest bit retired by end-of-interrupt.
module irq_isr_track #(
  parameter int N_LINES = 8,
  localparam int IDX_W  = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] set_oh_i,
  input  logic               eoi_i,
  output logic [N_LINES-1:0] isr_o,
  output logic               top_found_o,
  output logic [IDX_W-1:0]   top_idx_o
);

  logic [N_LINES-1:0] isr_q, isr_d;
  logic [N_LINES-1:0] eoi_clr;
  logic               isr_en;

  irq_prio_enc #(.N_LINES(N_LINES)) u_top_enc (
    .bits_i  (isr_q),
    .found_o (top_found_o),
    .idx_o   (top_idx_o)
  );

  for (genvar g = 0; g < N_LINES; g++) begin : g_eoi_dec
    assign eoi_clr[g] = eoi_i && top_found_o && (top_idx_o == IDX_W'(g));
  end

  always_comb begin
    isr_d  = (isr_q & ~eoi_clr) | set_oh_i;
    isr_en = eoi_i | (|set_oh_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q <= '0;
    end else if (isr_en) begin
      isr_q <= isr_d;
    end
  end

  assign isr_o = isr_q;

endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_vec_pkg::*;
#(
  parameter int N_LINES  = 8,
  parameter int VEC_W    = 8,
  parameter int CAS_LINE = 2,
  localparam int IDX_W   = (N_LINES > 1) ? $clog2(N_LINES) : 1,
  localparam int BASE_W  = VEC_W - IDX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] irq_req,
  input  logic               mask_we,
  input  logic [N_LINES-1:0] mask_wdata,
  input  logic [BASE_W-1:0]  vec_base,
  input  logic               cascade_en,
  input  logic               inta,
  input  logic               eoi,
  output logic               intr,
  output logic               vec_valid,
  output logic [VEC_W-1:0]   vec_data,
  output logic               cas_ack
);

  logic [N_LINES-1:0] pend_q, mask_q, isr_q;
  logic [N_LINES-1:0] cand, take_oh;
  logic               cand_found, isr_found, ack_take;
  logic [IDX_W-1:0]   cand_idx, isr_idx;
  ack_kind_e          ack_d, ack_q;
  logic [VEC_W-1:0]   vec_d, vec_q;

  irq_pend_bank #(.N_LINES(N_LINES)) u_pend (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_i        (irq_req),
    .clr_oh_i     (take_oh),
    .mask_we_i    (mask_we),
    .mask_wdata_i (mask_wdata),
    .pend_o       (pend_q),
    .mask_o       (mask_q)
  );

  assign cand = pend_q & ~mask_q;

  irq_prio_enc #(.N_LINES(N_LINES)) u_arb (
    .bits_i  (cand),
    .found_o (cand_found),
    .idx_o   (cand_idx)
  );

  irq_isr_track #(.N_LINES(N_LINES)) u_isr (
    .clk         (clk),
    .rst_n       (rst_n),
    .set_oh_i    (take_oh),
    .eoi_i       (eoi),
    .isr_o       (isr_q),
    .top_found_o (isr_found),
    .top_idx_o   (isr_idx)
  );

  // Raise the request only if the winner outranks everything in service.
  assign intr     = cand_found && (!isr_found || (cand_idx < isr_idx));
  assign ack_take = inta && intr;

  for (genvar g = 0; g < N_LINES; g++) begin : g_take_dec
    assign take_oh[g] = ack_take && (cand_idx == IDX_W'(g));
  end

  // Next state of the response stage.
  always_comb begin
    ack_d = ACK_IDLE;
    vec_d = vec_q;
    if (ack_take) begin
      if (cascade_en && (cand_idx == IDX_W'(CAS_LINE))) begin
        ack_d = ACK_CASCADE;
      end else begin
        ack_d = ACK_LOCAL;
        vec_d = {vec_base, cand_idx};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q <= ACK_IDLE;
    end else begin
      ack_q <= ack_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q <= '0;
    end else if (ack_take) begin
      vec_q <= vec_d;
    end
  end

  assign vec_valid = (ack_q == ACK_LOCAL);
  assign cas_ack   = (ack_q == ACK_CASCADE);
  assign vec_data  = vec_q;

endmodule

// File: rtl/irq_vec_ctrl_chk.sv
module irq_vec_ctrl_chk #(
  parameter int N_LINES = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               inta,
  input logic               eoi,
  input logic               intr,
  input logic               vec_valid,
  input logic               cas_ack,
  input logic [N_LINES-1:0] pend_q,
  input logic [N_LINES-1:0] mask_q,
  input logic [N_LINES-1:0] isr_q
);

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_quiet_r1: assert (!vec_valid && !cas_ack && !intr && (mask_q == '0));
    end
  end

  p_vec_after_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> $past(inta && intr));

  p_intr_unmasked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    intr |-> (|(pend_q & ~mask_q)));

  p_ack_sets_isr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && intr && !eoi) |=> ($countones(isr_q) == $countones($past(isr_q)) + 1));

  p_eoi_one_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !(inta && intr) && (isr_q != '0)) |=>
      ($countones(isr_q) == $countones($past(isr_q)) - 1));

  p_cas_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cas_ack |-> (!vec_valid && $past(inta && intr)));

  p_spurious_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && !intr) |=> (!vec_valid && !cas_ack));

endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk #(.N_LINES(N_LINES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .inta      (inta),
  .eoi       (eoi),
  .intr      (intr),
  .vec_valid (vec_valid),
  .cas_ack   (cas_ack),
  .pend_q    (pend_q),
  .mask_q    (mask_q),
  .isr_q     (isr_q)
);

// File: tb/irq_vec_ctrl_tb.sv
module irq_vec_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int CAS_CODE   = 256;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] irq_req;
  logic       mask_we;
  logic [7:0] mask_wdata;
  logic [4:0] vec_base;
  logic       cascade_en;
  logic       inta;
  logic       eoi;
  logic       intr;
  logic       vec_valid;
  logic [7:0] vec_data;
  logic       cas_ack;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  int exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_vec_ctrl u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_req    (irq_req),
    .mask_we    (mask_we),
    .mask_wdata (mask_wdata),
    .vec_base   (vec_base),
    .cascade_en (cascade_en),
    .inta       (inta),
    .eoi        (eoi),
    .intr       (intr),
    .vec_valid  (vec_valid),
    .vec_data   (vec_data),
    .cas_ack    (cas_ack)
  );

  task automatic chk_eq(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor: compares every produced response against the scoreboard queue.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst_n && (vec_valid || cas_ack)) begin
        int got;
        got = cas_ack ? CAS_CODE : int'(vec_data);
        if (vec_valid && cas_ack) chk_eq("R9 vector and cascade together", 1, 0);
        if (exp_q.size() == 0) begin
          chk_eq("R10 unexpected response", got, -1);
        end else begin
          chk_eq("R3 vector value", got, exp_q.pop_front());
        end
      end
    end
  end

  task automatic pulse_req(input logic [7:0] bits);
    @(negedge clk) irq_req = bits;
    @(negedge clk) irq_req = '0;
  endtask

  task automatic do_ack(input int exp);
    exp_q.push_back(exp);
    @(negedge clk) inta = 1'b1;
    @(negedge clk) inta = 1'b0;
    @(negedge clk);
    chk_eq("R3 one-cycle vec_valid", int'(vec_valid), 0);
  endtask

  task automatic do_eoi();
    @(negedge clk) eoi = 1'b1;
    @(negedge clk) eoi = 1'b0;
  endtask

  task automatic write_mask(input logic [7:0] m);
    @(negedge clk) begin mask_we = 1'b1; mask_wdata = m; end
    @(negedge clk) mask_we = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n      = 1'b0;
    irq_req    = '0;
    mask_we    = 1'b0;
    mask_wdata = '0;
    vec_base   = 5'h0A;
    cascade_en = 1'b0;
    inta       = 1'b0;
    eoi        = 1'b0;
    repeat (3) @(negedge clk);
    chk_eq("R1 intr in reset", int'(intr), 0);
    chk_eq("R1 vec_valid in reset", int'(vec_valid), 0);
    chk_eq("R1 cas_ack in reset", int'(cas_ack), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_eq("R1 intr after reset", int'(intr), 0);

    // R4/R7: single-cycle pulse on line 5 is held and served.
    pulse_req(8'h20);
    chk_eq("R4 intr raised for line 5", int'(intr), 1);
    @(negedge clk);
    chk_eq("R7 request held pending", int'(intr), 1);
    do_ack(8'h55);
    chk_eq("R7 pending cleared, line 5 in service", int'(intr), 0);

    // R5: lower line waits, higher line pre-empts.
    pulse_req(8'h40);
    chk_eq("R5 lower request blocked", int'(intr), 0);
    pulse_req(8'h20);
    chk_eq("R5 equal request blocked", int'(intr), 0);
    pulse_req(8'h08);
    chk_eq("R5 higher request pre-empts", int'(intr), 1);
    do_ack(8'h53);
    chk_eq("R5 nested handler blocks", int'(intr), 0);

    // R8: end-of-interrupt retires the highest bit only. Lines 5 and 6 pending.
    do_eoi();
    chk_eq("R8 line 5 still in service blocks line 5/6", int'(intr), 0);
    do_eoi();
    chk_eq("R8 line 5 retired, pending line 5 wins", int'(intr), 1);
    do_ack(8'h55);
    do_eoi();
    do_ack(8'h56);
    do_eoi();
    chk_eq("R8 all retired", int'(intr), 0);

    // R2: fixed priority among simultaneous requests.
    pulse_req(8'h92);
    do_ack(8'h51);
    do_eoi();
    do_ack(8'h54);
    do_eoi();
    do_ack(8'h57);
    do_eoi();

    // R6: masked line stays pending.
    write_mask(8'h01);
    pulse_req(8'h01);
    chk_eq("R6 masked line silent", int'(intr), 0);
    repeat (2) @(negedge clk);
    chk_eq("R6 masked line still silent", int'(intr), 0);
    write_mask(8'h00);
    chk_eq("R6 unmasked line served", int'(intr), 1);
    do_ack(8'h50);
    do_eoi();

    // R10: acknowledge with nothing pending.
    @(negedge clk) inta = 1'b1;
    @(negedge clk) inta = 1'b0;
    @(negedge clk);
    chk_eq("R10 no vector on spurious ack", int'(vec_valid), 0);
    chk_eq("R10 intr stays low", int'(intr), 0);

    // R9: cascade line outranks line 3 and hands off its acknowledge.
    cascade_en = 1'b1;
    pulse_req(8'h0C);
    chk_eq("R9 cascade request raises intr", int'(intr), 1);
    do_ack(CAS_CODE);
    chk_eq("R9 cascade in service blocks line 3", int'(intr), 0);
    do_eoi();
    do_ack(8'h53);
    do_eoi();
    cascade_en = 1'b0;

    // R3: new base takes effect.
    vec_base = 5'h1F;
    pulse_req(8'h01);
    do_ack(8'hF8);
    do_eoi();

    repeat (3) @(negedge clk);
    chk_eq("R3 all expected vectors seen", exp_q.size(), 0);
    finish_run();
  end

endmodule